// File: doc/BRIEF.md
# Seven-to-one serial video link transmitter

This block sends one RGB pixel per pixel clock, together with its display-enable, vertical-sync and horizontal-sync flags, over a small set of serial lanes. Every pixel is split into 7-bit words, one word per data lane. Each lane sends its word one bit at a time on a bit clock that runs seven times faster than the pixel clock. A separate clock lane sends a fixed 7-bit pattern that is locked to the word boundaries. A receiver can therefore find the start of each word from the clock lane alone, and no synchronization word is ever sent.

Parameter `BPC` sets the bits per colour. At 6 the block has three data lanes, which carry 18 colour bits and 3 control bits. At 8 it has four data lanes. With 8 bits per colour, a select input chooses between two layouts. In the low-bits-first layout, the six low bits of each colour stay on the first three lanes and the two top bits move to the fourth lane. In the high-bits-first layout, the six top bits stay on the first three lanes and the two low bits move to the fourth lane. The pixel word is captured on the pixel clock. It is moved into the per-lane shift registers when the bit counter wraps from its last bit position back to its first.

Top module: `vidlink_tx`

## Requirements
- R1: Each data lane sends exactly 7 bits per pixel period, most significant first (word bit 6 first, bit 0 last), and every word begins in the same bit slot in which the clock-lane pattern begins.
- R2: The clock lane repeats the 7-bit pattern 1100011 (first-sent bit on the left) every pixel period, so it rises once per word, between word bits 2 and 1.
- R3: Lane 0 carries {G[0], R[5:0]}, lane 1 carries {B[1:0], G[5:1]}, and lane 2 carries {DE, VSYNC, HSYNC, B[5:2]}, each written from word bit 6 down to bit 0. Here R, G and B are the 6-bit colour values chosen by the layout (R4, R5).
- R4: The control flags always sit in word bits 6, 5 and 4 of lane 2, in the order DE, VSYNC, HSYNC, whatever layout is chosen.
- R5: With 8 bits per colour and map_sel = 0 (low-bits-first), the 6-bit values are the colours' bits [5:0]. Lane 3 carries {0, B[7:6], G[7:6], R[7:6]}, and its bit 6 is a reserved bit that is always 0.
- R6: With 8 bits per colour and map_sel = 1 (high-bits-first), the 6-bit values are the colours' bits [7:2]. Lane 3 carries {0, B[1:0], G[1:0], R[1:0]}.
- R7: While rst is high, every data lane outputs 0 and the clock lane holds the pattern's first bit (1). The first complete word sent after reset is released is all zeros on every lane, and it starts at the first bit of the pattern.
- R8: A new pixel takes effect only at a word boundary. Every word seen on the lanes is a whole word from a single pixel, even when the pixel changes on every pixel clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the pixel inputs are captured on its rising edge |
| bit_clk | input | 1 | Bit clock at seven times the pixel rate, phase-locked to pix_clk |
| rst | input | 1 | Synchronous reset, active high, seen in both clock domains |
| pix_rgb | input | 3*BPC | Pixel colour, packed as {R, G, B} with BPC bits each |
| pix_de | input | 1 | Display enable flag |
| pix_hs | input | 1 | Horizontal sync flag |
| pix_vs | input | 1 | Vertical sync flag |
| map_sel | input | 1 | Layout select: 0 low-bits-first, 1 high-bits-first |
| lane_sd | output | LANES | Serial data bit of each data lane (LANES = 4 when BPC = 8, else 3) |
| clk_sd | output | 1 | Serial clock-lane bit |

## Verification
In a single bit clock, two things can happen together. The shift registers can load the next pixel word, and the clock lane can wrap back to its first bit while the last bit of the current word is still going out. The bench provokes this in two ways: it walks a vector table, and it changes the pixel on every pixel clock back to back. It rebuilds each word from the serial lanes wherever the clock lane shows the 1100011 frame. Every rebuilt word must match, lane for lane, one of the last three pixels applied, so a torn word or a misplaced wrap fails.

// File: rtl/vl_pkg.sv
package vl_pkg;
    localparam int unsigned WORD_W = 7;
    localparam int unsigned CNT_W  = 3;
    localparam logic [WORD_W-1:0] CLK_PATTERN = 7'b1100011;
    localparam logic [CNT_W-1:0]  LAST_SLOT   = CNT_W'(WORD_W - 1);

    typedef enum logic {
        MAP_LOW_FIRST  = 1'b0,
        MAP_HIGH_FIRST = 1'b1
    } map_e;
endpackage

// File: rtl/vl_bit_seq.sv
module vl_bit_seq
    import vl_pkg::*;
(
    input  logic             bit_clk,
    input  logic             rst,
    output logic [CNT_W-1:0] slot,
    output logic             load,
    output logic             clk_sd
);
    typedef struct packed {
        logic [CNT_W-1:0] slot;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.slot = '0;
        end else if (s_q.slot == LAST_SLOT) begin
            s_d.slot = '0;
        end else begin
            s_d.slot = s_q.slot + 1'b1;
        end
    end

    always_ff @(posedge bit_clk) begin
        s_q <= s_d;
    end

    assign slot   = s_q.slot;
    assign load   = (s_q.slot == LAST_SLOT);
    assign clk_sd = CLK_PATTERN[LAST_SLOT - s_q.slot];

    // R1: the slot counter wraps from the last slot back to the first
    a_r1_slot_wrap: assert property (@(posedge bit_clk) disable iff (rst)
        (s_q.slot == LAST_SLOT) |=> (s_q.slot == '0));

    // R1: the slot counter never leaves its range
    a_r1_slot_range: assert property (@(posedge bit_clk) disable iff (rst)
        (s_q.slot <= LAST_SLOT));

    // R2: the clock lane rises only between word bits 2 and 1
    a_r2_clk_rise: assert property (@(posedge bit_clk) disable iff (rst)
        $rose(clk_sd) |-> (s_q.slot == 3'd5));
endmodule

// File: rtl/vl_mapper.sv
module vl_mapper
    import vl_pkg::*;
#(
    parameter int unsigned BPC   = 8,
    localparam int unsigned LANES = (BPC == 8) ? 4 : 3,
    localparam int unsigned RGB_W = 3 * BPC
)(
    input  logic                          pix_clk,
    input  logic                          rst,
    input  logic [RGB_W-1:0]              pix_rgb,
    input  logic                          pix_de,
    input  logic                          pix_hs,
    input  logic                          pix_vs,
    input  logic                          map_sel,
    output logic [LANES-1:0][WORD_W-1:0]  words
);
    typedef struct packed {
        logic [LANES-1:0][WORD_W-1:0] words;
    } map_t;

    map_t m_d, m_q;

    logic [BPC-1:0] r_in, g_in, b_in;
    logic [5:0]     r6, g6, b6;
    logic [LANES-1:0][WORD_W-1:0] packed_w;

    assign r_in = pix_rgb[RGB_W-1 -: BPC];
    assign g_in = pix_rgb[2*BPC-1 -: BPC];
    assign b_in = pix_rgb[BPC-1:0];

    generate
        if (BPC == 8) begin : g_wide
            logic [1:0] rx, gx, bx;
            always_comb begin
                if (map_e'(map_sel) == MAP_HIGH_FIRST) begin
                    r6 = r_in[7:2]; g6 = g_in[7:2]; b6 = b_in[7:2];
                    rx = r_in[1:0]; gx = g_in[1:0]; bx = b_in[1:0];
                end else begin
                    r6 = r_in[5:0]; g6 = g_in[5:0]; b6 = b_in[5:0];
                    rx = r_in[7:6]; gx = g_in[7:6]; bx = b_in[7:6];
                end
            end
            assign packed_w[3] = {1'b0, bx, gx, rx};
        end else begin : g_narrow
            assign r6 = r_in;
            assign g6 = g_in;
            assign b6 = b_in;
        end
    endgenerate

    assign packed_w[0] = {g6[0], r6};
    assign packed_w[1] = {b6[1:0], g6[5:1]};
    assign packed_w[2] = {pix_de, pix_vs, pix_hs, b6[5:2]};

    always_comb begin
        m_d = m_q;
        if (rst) begin
            m_d.words = '0;
        end else begin
            m_d.words = packed_w;
        end
    end

    always_ff @(posedge pix_clk) begin
        m_q <= m_d;
    end

    assign words = m_q.words;

    // R4: the captured control flags come from the previous pixel-clock inputs
    a_r4_ctrl_slot: assert property (@(posedge pix_clk) disable iff (rst)
        1'b1 |=> (m_q.words[2][6:4] == $past({pix_de, pix_vs, pix_hs})));
endmodule

// File: rtl/vl_lane_ser.sv
module vl_lane_ser
    import vl_pkg::*;
(
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              sd
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } ser_t;

    ser_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (rst) begin
            l_d.sh = '0;
        end else if (load) begin
            l_d.sh = word;
        end else begin
            l_d.sh = {l_q.sh[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge bit_clk) begin
        l_q <= l_d;
    end

    assign sd = l_q.sh[WORD_W-1];

    // R8: a wrap transfers the whole captured word at once
    a_r8_load_word: assert property (@(posedge bit_clk) disable iff (rst)
        load |=> (l_q.sh == $past(word)));

    // R1: between wraps the word moves one bit toward the output
    a_r1_shift_msb: assert property (@(posedge bit_clk) disable iff (rst)
        !load |=> (l_q.sh[WORD_W-1:1] == $past(l_q.sh[WORD_W-2:0])));
endmodule

// File: rtl/vidlink_tx.sv
module vidlink_tx
    import vl_pkg::*;
#(
    parameter int unsigned BPC   = 8,
    localparam int unsigned LANES = (BPC == 8) ? 4 : 3,
    localparam int unsigned RGB_W = 3 * BPC
)(
    input  logic             pix_clk,
    input  logic             bit_clk,
    input  logic             rst,
    input  logic [RGB_W-1:0] pix_rgb,
    input  logic             pix_de,
    input  logic             pix_hs,
    input  logic             pix_vs,
    input  logic             map_sel,
    output logic [LANES-1:0] lane_sd,
    output logic             clk_sd
);
    logic [LANES-1:0][WORD_W-1:0] words;
    logic [CNT_W-1:0]             slot;
    logic                         load;

    vl_mapper #(.BPC(BPC)) u_map (
        .pix_clk (pix_clk),
        .rst     (rst),
        .pix_rgb (pix_rgb),
        .pix_de  (pix_de),
        .pix_hs  (pix_hs),
        .pix_vs  (pix_vs),
        .map_sel (map_sel),
        .words   (words)
    );

    vl_bit_seq u_seq (
        .bit_clk (bit_clk),
        .rst     (rst),
        .slot    (slot),
        .load    (load),
        .clk_sd  (clk_sd)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            vl_lane_ser u_ser (
                .bit_clk (bit_clk),
                .rst     (rst),
                .load    (load),
                .word    (words[i]),
                .sd      (lane_sd[i])
            );
        end
    endgenerate

    // R7: one cycle into reset the lanes are quiet and the pattern is at its start
    a_r7_reset_idle: assert property (@(posedge bit_clk)
        rst |=> ((lane_sd == '0) && clk_sd));

    // R1: a word starts on the lanes in the slot where the clock pattern starts
    a_r1_word_start: assert property (@(posedge bit_clk) disable iff (rst)
        load |=> ((slot == '0) && clk_sd));
endmodule

// File: tb/tb_vidlink_tx.sv
module tb_vidlink_tx;
    import vl_pkg::*;

    logic        bit_clk = 1'b0;
    logic        pix_clk = 1'b0;
    logic        rst     = 1'b1;
    logic [23:0] pix_rgb = '0;
    logic        pix_de  = 1'b0;
    logic        pix_hs  = 1'b0;
    logic        pix_vs  = 1'b0;
    logic        map_sel = 1'b0;
    logic [3:0]  lane_sd;
    logic        clk_sd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    vidlink_tx #(.BPC(8)) dut (
        .pix_clk (pix_clk),
        .bit_clk (bit_clk),
        .rst     (rst),
        .pix_rgb (pix_rgb),
        .pix_de  (pix_de),
        .pix_hs  (pix_hs),
        .pix_vs  (pix_vs),
        .map_sel (map_sel),
        .lane_sd (lane_sd),
        .clk_sd  (clk_sd)
    );

    always #4 bit_clk = ~bit_clk;

    int tcnt = 0;
    always @(negedge bit_clk) begin
        tcnt    <= (tcnt == 6) ? 0 : tcnt + 1;
        pix_clk <= (tcnt >= 1 && tcnt <= 3);
    end

    // vector: {sel, de, vs, hs, r[7:0], g[7:0], b[7:0]}
    typedef logic [3:0][6:0] frame_t;

    function automatic frame_t expw(logic [27:0] v);
        logic [7:0] r, g, b;
        logic [5:0] r6, g6, b6;
        logic [1:0] rx, gx, bx;
        frame_t w;
        r = v[23:16]; g = v[15:8]; b = v[7:0];
        if (v[27]) begin
            r6 = r[7:2]; g6 = g[7:2]; b6 = b[7:2];
            rx = r[1:0]; gx = g[1:0]; bx = b[1:0];
        end else begin
            r6 = r[5:0]; g6 = g[5:0]; b6 = b[5:0];
            rx = r[7:6]; gx = g[7:6]; bx = b[7:6];
        end
        w[0] = {g6[0], r6};
        w[1] = {b6[1:0], g6[5:1]};
        w[2] = {v[26], v[25], v[24], b6[5:2]};
        w[3] = {1'b0, bx, gx, rx};
        return w;
    endfunction

    localparam int NVEC = 8;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'b0100, 8'hC5, 8'h3A, 8'h96},
        {4'b1100, 8'hC5, 8'h3A, 8'h96},
        {4'b0010, 8'h00, 8'h00, 8'h00},
        {4'b0001, 8'hFF, 8'hFF, 8'hFF},
        {4'b1111, 8'hFF, 8'hFF, 8'hFF},
        {4'b0000, 8'h81, 8'h42, 8'h24},
        {4'b1000, 8'h81, 8'h42, 8'h24},
        {4'b1101, 8'h5A, 8'hA5, 8'h0F}
    };

    // serial capture
    logic [6:0] ch = '0;
    logic [3:0][6:0] lh = '0;
    frame_t last_frame = '0;
    int nframes = 0;
    bit mon_on = 1'b0;
    frame_t eh0 = '0, eh1 = '0, eh2 = '0;

    always @(negedge bit_clk) begin
        logic [6:0] cur;
        frame_t f;
        cur = {ch[5:0], clk_sd};
        for (int i = 0; i < 4; i++) f[i] = {lh[i][5:0], lane_sd[i]};
        ch <= cur;
        lh <= f;
        if (cur == CLK_PATTERN) begin
            last_frame = f;
            nframes    = nframes + 1;
            if (mon_on && !rst) begin
                n_chk++;
                if (f != eh0 && f != eh1 && f != eh2) begin
                    n_fail++;
                    $display("FAIL R8 torn word: actual %h expected %h or %h or %h",
                             f, eh0, eh1, eh2);
                end
            end
        end
    end

    task automatic check(input logic [27:0] act, input logic [27:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [27:0] v);
        map_sel = v[27]; pix_de = v[26]; pix_vs = v[25]; pix_hs = v[24];
        pix_rgb = v[23:0];
        eh2 = eh1; eh1 = eh0; eh0 = expw(v);
    endtask

    task automatic wait_frames(input int n);
        int s;
        s = nframes;
        wait (nframes >= s + n);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (20) @(negedge bit_clk);
        // R7: reset state on the pins
        check({24'd0, clk_sd, lane_sd}, {24'd0, 1'b1, 4'b0000}, "R7 reset idle");
        rst = 1'b0;
        wait_frames(1);
        check(28'(last_frame), 28'd0, "R7 first word after reset");

        // table walk: R3, R4, R5, R6, R1, R2
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k]);
            wait_frames(3);
            eh1 = eh0; eh2 = eh0;
            mon_on = 1'b1;
            check(28'(last_frame), 28'(expw(VEC[k])),
                  VEC[k][27] ? "R6 R3 R4 high-bits-first" : "R5 R3 R4 low-bits-first");
        end

        // R5: reserved bit stays 0 with all colour bits set
        drive({4'b0111, 24'hFFFFFF});
        wait_frames(3);
        eh1 = eh0; eh2 = eh0;
        check({21'd0, last_frame[3]}, {21'd0, 7'b0111111}, "R5 reserved bit");

        // R8: pixel changes on every pixel clock
        for (int k = 0; k < 40; k++) begin
            @(posedge pix_clk);
            #1;
            drive({k[0], k[1], k[2], k[3], 8'(k * 37), 8'(k * 91 + 5), 8'(k * 13 + 200)});
        end
        wait_frames(3);
        eh1 = eh0; eh2 = eh0;

        // R7: reset mid-stream
        drive({4'b0100, 24'hFFFFFF});
        wait_frames(3);
        mon_on = 1'b0;
        @(negedge bit_clk);
        rst = 1'b1;
        repeat (3) @(negedge bit_clk);
        check({24'd0, clk_sd, lane_sd}, {24'd0, 1'b1, 4'b0000}, "R7 reset mid-stream");
        repeat (8) @(negedge bit_clk);
        rst = 1'b0;
        wait_frames(1);
        check(28'(last_frame), 28'd0, "R7 zero word after mid-stream reset");
        wait_frames(3);
        check(28'(last_frame), 28'(expw({4'b0100, 24'hFFFFFF})), "R1 R2 resume after reset");

        finish_run();
    end
endmodule